// File: doc/BRIEF.md
# Packed Byte/Halfword Shuffle Unit

This block is a combinational lane permutation unit for 64-bit packed data. It receives two source words, `vs_i` and `vt_i`, and a 5-bit shuffle opcode. It builds the result word from whole lanes of the two sources. The lanes are either eight bytes or four halfwords. In byte lanes the unit provides interleave (mix), even/odd pack and upsample. Upsample pairs each low byte of `vs_i` with a sign-fill byte. In halfword lanes the unit provides interleave, pack-high, butterfly and two half-replicate patterns.

The surrounding datapath sends its operands and the opcode field to the unit and takes the result in the same cycle. An opcode that names no pattern gives a zero result and raises `illegal_o`, so that the decode logic can trap it. Result lane 0 is always the least significant lane. In the requirements below, byte lane k is bits [8k+7:8k], halfword lane k is bits [16k+15:16k], and lists of lanes are written from result lane 0 upward.

Top module: `packed_shuffle`

## Requirements
- R1: The format is taken from the low opcode bits. op[0]=0 selects byte lanes, with the pattern code in op[4:1]. op[1:0]=01 selects halfword lanes, with the pattern code in op[4:2]. op[1:0]=11 is always illegal.
- R2: Byte mix-high (op=5'b01010) gives vt4, vs4, vt5, vs5, vt6, vs6, vt7, vs7.
- R3: Byte mix-low (op=5'b01100) gives vt0, vs0, vt1, vs1, vt2, vs2, vt3, vs3.
- R4: Byte pack-high (op=5'b00110) gives vt1, vt3, vt5, vt7, vs1, vs3, vs5, vs7.
- R5: Byte pack-low (op=5'b01000) gives vt0, vt2, vt4, vt6, vs0, vs2, vs4, vs6.
- R6: Byte upsample (op=5'b00100) gives vs0, f0, vs1, f1, vs2, f2, vs3, f3. Here fk is 8'hFF when bit 7 of vs byte k is 1, and 8'h00 otherwise.
- R7: Halfword mix-high (op=5'b00001) gives vt2, vs2, vt3, vs3. Mix-low (op=5'b00101) gives vt0, vs0, vt1, vs1. Pack-high (op=5'b01001) gives vt1, vt3, vs1, vs3.
- R8: Halfword butterfly (op=5'b10001) gives vt1, vs0, vt3, vs2. Replicate-A (op=5'b11001) gives vt2, vt3, vs2, vs3. Replicate-B (op=5'b11101) gives vt0, vt1, vs0, vs1.
- R9: Every other opcode is illegal and gives `res_o`=0 with `illegal_o`=1. These are byte codes 0, 1 and 7 to 15, halfword codes 3 and 5, and every opcode with op[1:0]=11. For the opcodes in R2 to R8, `illegal_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Shuffle opcode: format and pattern |
| vs_i | input | 64 | First source word |
| vt_i | input | 64 | Second source word |
| res_o | output | 64 | Permuted result |
| illegal_o | output | 1 | Opcode names no pattern |

## Verification
All 32 opcodes are applied with each of several operand pairs, so every legal pattern and every illegal code is covered. The lane-index operands give every byte a distinct value in both sources, which shows any wrong lane, wrong source or wrong order. Operands with bit 7 alternating across the bytes drive both sign-fill values in upsample and show whether the fill is taken from the correct byte. All-zero, all-ones and pseudo-random pairs show stuck bits, and they show that illegal codes clear the result whatever the data is.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  // byte pattern codes (op[4:1])
  localparam logic [3:0] BC_UPS  = 4'd2;
  localparam logic [3:0] BC_PACH = 4'd3;
  localparam logic [3:0] BC_PACL = 4'd4;
  localparam logic [3:0] BC_MIXH = 4'd5;
  localparam logic [3:0] BC_MIXL = 4'd6;
  // halfword pattern codes (op[4:2])
  localparam logic [2:0] HC_MIXH = 3'd0;
  localparam logic [2:0] HC_MIXL = 3'd1;
  localparam logic [2:0] HC_PACH = 3'd2;
  localparam logic [2:0] HC_BFLY = 3'd4;
  localparam logic [2:0] HC_REPA = 3'd6;
  localparam logic [2:0] HC_REPB = 3'd7;

  typedef enum logic [1:0] {FMT_BYTE, FMT_HALF, FMT_NONE} fmt_e;
endpackage

// File: rtl/shuf_byte_path.sv
module shuf_byte_path
  import shuf_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int N_LANES = 8
) (
  input  logic [N_LANES*LANE_W-1:0] vs_i,
  input  logic [N_LANES*LANE_W-1:0] vt_i,
  input  logic [3:0]                code_i,
  output logic [N_LANES*LANE_W-1:0] res_o,
  output logic                      legal_o
);
  localparam int HALF   = N_LANES / 2;
  localparam int DATA_W = N_LANES * LANE_W;
  localparam int HW     = DATA_W / 2;

  assign legal_o = (code_i == BC_UPS) || (code_i == BC_PACH) || (code_i == BC_PACL) ||
                   (code_i == BC_MIXH) || (code_i == BC_MIXL);

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int  PAIR  = g / 2;
    localparam bit  ODD   = (g % 2) == 1;
    localparam bit  UPPER = g >= HALF;
    localparam int  PK_LO = 2 * (g % HALF);
    localparam int  PK_HI = PK_LO + 1;

    logic [LANE_W-1:0] lane;
    always_comb begin
      unique case (code_i)
        BC_MIXH: lane = ODD ? vs_i[(HALF+PAIR)*LANE_W +: LANE_W]
                            : vt_i[(HALF+PAIR)*LANE_W +: LANE_W];
        BC_MIXL: lane = ODD ? vs_i[PAIR*LANE_W +: LANE_W]
                            : vt_i[PAIR*LANE_W +: LANE_W];
        BC_PACH: lane = UPPER ? vs_i[PK_HI*LANE_W +: LANE_W]
                              : vt_i[PK_HI*LANE_W +: LANE_W];
        BC_PACL: lane = UPPER ? vs_i[PK_LO*LANE_W +: LANE_W]
                              : vt_i[PK_LO*LANE_W +: LANE_W];
        BC_UPS:  lane = ODD ? {LANE_W{vs_i[PAIR*LANE_W+LANE_W-1]}}
                            : vs_i[PAIR*LANE_W +: LANE_W];
        default: lane = '0;
      endcase
    end
    assign res_o[g*LANE_W +: LANE_W] = lane;

    if (ODD) begin : g_sign_chk
      always_comb begin
        if (code_i == BC_UPS)
          AST_UPS_SIGN_FILL: assert (res_o[g*LANE_W +: LANE_W] ==
                                     {LANE_W{res_o[g*LANE_W-1]}}); // R6
      end
    end
  end

  // packing a word with itself yields identical halves
  always_comb begin
    if ((code_i == BC_PACH || code_i == BC_PACL) && vs_i == vt_i)
      AST_PACK_SELF_HALVES: assert (res_o[DATA_W-1:HW] == res_o[HW-1:0]); // R4
  end
endmodule

// File: rtl/shuf_half_path.sv
module shuf_half_path
  import shuf_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int N_LANES = 4
) (
  input  logic [N_LANES*LANE_W-1:0] vs_i,
  input  logic [N_LANES*LANE_W-1:0] vt_i,
  input  logic [2:0]                code_i,
  output logic [N_LANES*LANE_W-1:0] res_o,
  output logic                      legal_o
);
  localparam int HALF   = N_LANES / 2;
  localparam int DATA_W = N_LANES * LANE_W;
  localparam int HW     = DATA_W / 2;

  assign legal_o = (code_i != 3'd3) && (code_i != 3'd5);

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int PAIR   = g / 2;
    localparam bit ODD    = (g % 2) == 1;
    localparam bit UPPER  = g >= HALF;
    localparam int MX_HI  = HALF + PAIR;
    localparam int PK_HI  = 2 * (g % HALF) + 1;
    localparam int BF_IDX = ODD ? g - 1 : g + 1;
    localparam int RA_IDX = UPPER ? g : HALF + g;
    localparam int RB_IDX = UPPER ? g - HALF : g;

    logic [LANE_W-1:0] lane;
    always_comb begin
      unique case (code_i)
        HC_MIXH: lane = ODD ? vs_i[MX_HI*LANE_W +: LANE_W] : vt_i[MX_HI*LANE_W +: LANE_W];
        HC_MIXL: lane = ODD ? vs_i[PAIR*LANE_W +: LANE_W]  : vt_i[PAIR*LANE_W +: LANE_W];
        HC_PACH: lane = UPPER ? vs_i[PK_HI*LANE_W +: LANE_W] : vt_i[PK_HI*LANE_W +: LANE_W];
        HC_BFLY: lane = ODD ? vs_i[BF_IDX*LANE_W +: LANE_W] : vt_i[BF_IDX*LANE_W +: LANE_W];
        HC_REPA: lane = UPPER ? vs_i[RA_IDX*LANE_W +: LANE_W] : vt_i[RA_IDX*LANE_W +: LANE_W];
        HC_REPB: lane = UPPER ? vs_i[RB_IDX*LANE_W +: LANE_W] : vt_i[RB_IDX*LANE_W +: LANE_W];
        default: lane = '0;
      endcase
    end
    assign res_o[g*LANE_W +: LANE_W] = lane;
  end

  // both replicate forms fill the upper result half from one half of vs
  always_comb begin
    if (code_i == HC_REPA)
      AST_REPA_UPPER_VS: assert (res_o[DATA_W-1:HW] == vs_i[DATA_W-1:HW]); // R8
    if (code_i == HC_REPB)
      AST_REPB_UPPER_VS: assert (res_o[DATA_W-1:HW] == vs_i[HW-1:0]); // R8
  end
endmodule

// File: rtl/packed_shuffle.sv
module packed_shuffle
  import shuf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int N_BYTE = 8
) (
  input  logic [4:0]               op_i,
  input  logic [BYTE_W*N_BYTE-1:0] vs_i,
  input  logic [BYTE_W*N_BYTE-1:0] vt_i,
  output logic [BYTE_W*N_BYTE-1:0] res_o,
  output logic                     illegal_o
);
  localparam int DATA_W = BYTE_W * N_BYTE;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int N_HALF = N_BYTE / 2;

  fmt_e              fmt;
  logic [DATA_W-1:0] byte_res, half_res;
  logic              byte_legal, half_legal;

  always_comb begin
    if (!op_i[0])              fmt = FMT_BYTE;
    else if (op_i[1:0] == 2'b01) fmt = FMT_HALF;
    else                       fmt = FMT_NONE;
  end

  shuf_byte_path #(.LANE_W(BYTE_W), .N_LANES(N_BYTE)) u_byte (
    .vs_i   (vs_i),
    .vt_i   (vt_i),
    .code_i (op_i[4:1]),
    .res_o  (byte_res),
    .legal_o(byte_legal)
  );

  shuf_half_path #(.LANE_W(HALF_W), .N_LANES(N_HALF)) u_half (
    .vs_i   (vs_i),
    .vt_i   (vt_i),
    .code_i (op_i[4:2]),
    .res_o  (half_res),
    .legal_o(half_legal)
  );

  always_comb begin
    res_o     = '0;
    illegal_o = 1'b1;
    unique case (fmt)
      FMT_BYTE: if (byte_legal) begin res_o = byte_res; illegal_o = 1'b0; end
      FMT_HALF: if (half_legal) begin res_o = half_res; illegal_o = 1'b0; end
      default: ;
    endcase
  end

  always_comb begin
    if (illegal_o)
      AST_ILLEGAL_ZERO: assert (res_o == '0); // R9
    if (op_i[1:0] == 2'b11)
      AST_FMT11_ILLEGAL: assert (illegal_o); // R1
  end
endmodule

// File: tb/tb_packed_shuffle.sv
module tb_packed_shuffle;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op;
  logic [63:0] vs, vt;
  logic [63:0] res;
  logic        ill;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  packed_shuffle dut (
    .op_i(op), .vs_i(vs), .vt_i(vt), .res_o(res), .illegal_o(ill)
  );

  function automatic logic [7:0] b(logic [63:0] v, int i);
    return v[8*i +: 8];
  endfunction
  function automatic logic [15:0] h(logic [63:0] v, int i);
    return v[16*i +: 16];
  endfunction
  function automatic logic [7:0] sf(logic [63:0] v, int i);
    return v[8*i+7] ? 8'hFF : 8'h00;
  endfunction

  // expected result (concatenations written from lane 7/3 down to lane 0)
  function automatic void model(input logic [4:0] o, input logic [63:0] s, input logic [63:0] t,
                                output logic [63:0] e, output logic il, output string tag);
    il = 1'b0;
    e  = '0;
    case (o)
      5'b01010: begin tag = "R2"; e = {b(s,7),b(t,7),b(s,6),b(t,6),b(s,5),b(t,5),b(s,4),b(t,4)}; end
      5'b01100: begin tag = "R3"; e = {b(s,3),b(t,3),b(s,2),b(t,2),b(s,1),b(t,1),b(s,0),b(t,0)}; end
      5'b00110: begin tag = "R4"; e = {b(s,7),b(s,5),b(s,3),b(s,1),b(t,7),b(t,5),b(t,3),b(t,1)}; end
      5'b01000: begin tag = "R5"; e = {b(s,6),b(s,4),b(s,2),b(s,0),b(t,6),b(t,4),b(t,2),b(t,0)}; end
      5'b00100: begin tag = "R6"; e = {sf(s,3),b(s,3),sf(s,2),b(s,2),sf(s,1),b(s,1),sf(s,0),b(s,0)}; end
      5'b00001: begin tag = "R7"; e = {h(s,3),h(t,3),h(s,2),h(t,2)}; end
      5'b00101: begin tag = "R7"; e = {h(s,1),h(t,1),h(s,0),h(t,0)}; end
      5'b01001: begin tag = "R7"; e = {h(s,3),h(s,1),h(t,3),h(t,1)}; end
      5'b10001: begin tag = "R8"; e = {h(s,2),h(t,3),h(s,0),h(t,1)}; end
      5'b11001: begin tag = "R8"; e = {h(s,3),h(s,2),h(t,3),h(t,2)}; end
      5'b11101: begin tag = "R8"; e = {h(s,1),h(s,0),h(t,1),h(t,0)}; end
      default:  begin tag = (o[1:0] == 2'b11) ? "R1" : "R9"; il = 1'b1; end
    endcase
  endfunction

  task automatic check_one(input logic [4:0] o, input logic [63:0] s, input logic [63:0] t);
    logic [63:0] e;
    logic        il;
    string       tag;
    @(negedge clk);
    op = o; vs = s; vt = t;
    #2;
    model(o, s, t, e, il, tag);
    checks++;
    if (res !== e || ill !== il) begin
      errors++;
      $display("FAIL %s op=%b vs=%h vt=%h res=%h ill=%b expected res=%h ill=%b",
               tag, o, s, t, res, ill, e, il);
    end
  endtask

  initial begin
    logic [63:0] lf;
    op = '0; vs = '0; vt = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // reset/idle state: zero operands, opcode 0 is an illegal byte code (R9)
    #1;
    checks++;
    if (res !== 64'h0 || ill !== 1'b1) begin
      errors++;
      $display("FAIL R9 idle res=%h ill=%b expected res=0 ill=1", res, ill);
    end
    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int o = 0; o < 32; o++) begin
      check_one(5'(o), 64'h0, 64'h0);
      check_one(5'(o), '1, '1);
      check_one(5'(o), 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);  // lane identity
      check_one(5'(o), 64'h807F_00FF_7F80_FF01, 64'hA5A5_5A5A_C3C3_3C3C);  // sign alternation R6
      check_one(5'(o), 64'h7F80_FF00_017F_80FE, 64'h0);
      check_one(5'(o), 64'h0, 64'h0123_4567_89AB_CDEF);
      for (int k = 0; k < 4; k++) begin
        logic [63:0] a;
        lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
        a  = lf;
        lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
        check_one(5'(o), a, lf ^ {a[31:0], a[63:32]});
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before all checks ran");
    end
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule